// File: doc/BRIEF.md
# Shadowed Nonvolatile I/O Register Bank

This block is the byte-addressed register file of a nine-pin open-drain I/O expander. A host reaches it over a plain parallel bus made of an 8-bit address, 8-bit write data, a write strobe, a read strobe, registered read data and a busy flag. Behind that bus sit 67 bytes of nonvolatile user memory, six bytes of volatile scratch SRAM, two read-only pin level registers and five control registers (pullup enables, pulldown controls and a configuration byte). Each control register has a fast shadow copy that drives the pins and a nonvolatile copy that supplies its power-up value.

Nonvolatile storage is modelled as an internal byte array. Each write to it opens a write cycle of `NV_WR_CLKS` clocks, during which busy is high and every further write is dropped. Bit 0 of the configuration byte selects the control register write mode. With it clear, a control write goes to both copies and opens a write cycle. With it set, the write touches only the shadow copy and completes at once, which suits hosts that toggle pins often.

A controller with three states runs the block. `ST_LOAD` is entered on reset and copies the five nonvolatile control bytes into the shadow registers, one per clock. On its fifth copy it takes the transition *load done* to `ST_IDLE`. In `ST_IDLE` writes are accepted. A write that reaches nonvolatile storage takes the transition *nv start* to `ST_NVWR`. That state counts `NV_WR_CLKS` clocks and then takes *nv done* back to `ST_IDLE`. Busy is high in every state except `ST_IDLE`.

Top module: `nvio_regbank`

## Requirements
- R1: While reset is asserted and during the five clocks after its release (state `ST_LOAD`), busy is high. The shadow registers are then loaded from nonvolatile storage. With factory contents (F0h=00h, F1h=00h, F2h=FFh, F3h=01h, F4h=00h) all `pullup_en` and `pulldown_en` bits read 0.
- R2: `pullup_en[7:0]` equals shadow register F0h bits 7..0, and `pullup_en[8]` equals bit 0 of F1h. A 1 enables the pullup.
- R3: `pulldown_en[7:0]` is the inverse of F2h bits 7..0, and `pulldown_en[8]` is the inverse of bit 0 of F3h. A control bit of 0 turns the pulldown on.
- R4: With the mode bit (F4h bit 0) at 0, a write to F0h..F4h updates the shadow at once and also the nonvolatile copy. Busy goes high on the next clock and stays high for exactly `NV_WR_CLKS` clocks.
- R5: With the mode bit at 1, a write to F0h..F4h updates only the shadow and busy stays low. After a reset the register takes its nonvolatile value again.
- R6: A write to user bytes 00h..3Fh or F5h..F7h stores the byte and opens a write cycle whatever the mode bit. The byte reads back and keeps its value across reset.
- R7: Bytes FAh..FFh are read/write SRAM that opens no write cycle and clears to 00h on reset.
- R8: Writes to 40h..EFh change no state and open no write cycle, and reads there return 00h.
- R9: F8h returns the pin levels of pins 7..0 and F9h bit 0 returns pin 8, each through a two-stage synchronizer. Writes to F8h/F9h have no effect.
- R10: Any write that arrives while busy is high is dropped.
- R11: Bits 7..1 of F1h, F3h, F4h and F9h always read as 0.
- R12: Read data is registered. It appears the clock after a cycle with `host_rd` high and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| host_busy | output | 1 | Power-up load or nonvolatile write in progress |
| pin_in | input | 9 | Asynchronous pin levels |
| pullup_en | output | 9 | Pullup enable per pin |
| pulldown_en | output | 9 | Pulldown enable per pin, 1 pulls the pin low |

## Verification
The assertions assume that the host strobes are synchronous to `clk`, that the address is stable in any cycle with a strobe high, and that `NV_WR_CLKS` is at least 1. The busy-run check also assumes that `NV_WR_CLKS` is small enough for a 32-bit counter. The bench drives every strobe and address half a clock away from the sampling edge and raises `host_wr` for one cycle per write. It raises `pin_in` changes a few clocks before reading the status bytes, so that the synchronizer latency never falls inside a check.

// File: rtl/nvio_pkg.sv
package nvio_pkg;

    localparam int PIN_COUNT    = 9;
    localparam int USER_LO_SIZE = 64;
    localparam int USER_HI_SIZE = 3;
    localparam int SHADOW_REGS  = 5;
    localparam int SRAM_SIZE    = 6;
    localparam int NV_DEPTH     = USER_LO_SIZE + USER_HI_SIZE + SHADOW_REGS;
    localparam int NV_IDX_W     = $clog2(NV_DEPTH);
    localparam int SHD_NV_BASE  = USER_LO_SIZE + USER_HI_SIZE;

    localparam logic [7:0] ADR_RSVD_LO = 8'h40;
    localparam logic [7:0] ADR_RSVD_HI = 8'hEF;
    localparam logic [7:0] ADR_SHD_LO  = 8'hF0;
    localparam logic [7:0] ADR_SHD_HI  = 8'hF4;
    localparam logic [7:0] ADR_UHI_LO  = 8'hF5;
    localparam logic [7:0] ADR_UHI_HI  = 8'hF7;
    localparam logic [7:0] ADR_STAT_LO = 8'hF8;
    localparam logic [7:0] ADR_STAT_HI = 8'hF9;
    localparam logic [7:0] ADR_SRAM_LO = 8'hFA;

    typedef enum logic [2:0] {
        RG_USER_NV,
        RG_SHADOW,
        RG_STATUS,
        RG_SRAM,
        RG_RESERVED
    } region_e;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_IDLE,
        ST_NVWR
    } state_e;

    function automatic logic [7:0] shadow_mask(input logic [2:0] idx);
        return (idx == 3'd1 || idx == 3'd3 || idx == 3'd4) ? 8'h01 : 8'hFF;
    endfunction

    function automatic logic [7:0] shadow_factory(input logic [2:0] idx);
        unique case (idx)
            3'd2:    return 8'hFF;
            3'd3:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nvio_decode.sv
module nvio_decode
    import nvio_pkg::*;
(
    input  logic [7:0]          addr,
    output region_e             region,
    output logic [NV_IDX_W-1:0] nv_idx,
    output logic [2:0]          sub_idx
);

    logic [7:0] off_shd;
    logic [7:0] off_uhi;
    logic [7:0] off_stat;
    logic [7:0] off_sram;

    assign off_shd  = addr - ADR_SHD_LO;
    assign off_uhi  = addr - ADR_UHI_LO;
    assign off_stat = addr - ADR_STAT_LO;
    assign off_sram = addr - ADR_SRAM_LO;

    always_comb begin
        region  = RG_RESERVED;
        nv_idx  = '0;
        sub_idx = '0;
        if (addr < ADR_RSVD_LO) begin
            region = RG_USER_NV;
            nv_idx = NV_IDX_W'(addr);
        end else if (addr <= ADR_RSVD_HI) begin
            region = RG_RESERVED;
        end else if (addr <= ADR_SHD_HI) begin
            region  = RG_SHADOW;
            sub_idx = off_shd[2:0];
            nv_idx  = NV_IDX_W'(SHD_NV_BASE) + NV_IDX_W'(off_shd[2:0]);
        end else if (addr <= ADR_UHI_HI) begin
            region = RG_USER_NV;
            nv_idx = NV_IDX_W'(USER_LO_SIZE) + NV_IDX_W'(off_uhi[1:0]);
        end else if (addr <= ADR_STAT_HI) begin
            region  = RG_STATUS;
            sub_idx = off_stat[2:0];
        end else begin
            region  = RG_SRAM;
            sub_idx = off_sram[2:0];
        end
    end

endmodule

// File: rtl/nvio_nvstore.sv
module nvio_nvstore
    import nvio_pkg::*;
#(
    parameter int DEPTH = NV_DEPTH,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] cells [DEPTH];

    // Modelled nonvolatile contents: factory image present before the first clock.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cells[i] = (i >= SHD_NV_BASE) ? DW'(shadow_factory(3'(i - SHD_NV_BASE))) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata_a = cells[ridx_a];
    assign rdata_b = cells[ridx_b];

endmodule

// File: rtl/nvio_ctrl_fsm.sv
module nvio_ctrl_fsm
    import nvio_pkg::*;
#(
    parameter int NV_WR_CLKS = 40,
    localparam int CNT_W     = $clog2(NV_WR_CLKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nv_start,
    output state_e     state,
    output logic       busy,
    output logic       load_en,
    output logic [2:0] load_idx
);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       idx_q, idx_d;

    // next-state and counters
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_LOAD: begin
                idx_d = idx_q + 3'd1;
                if (idx_q == 3'(SHADOW_REGS - 1)) begin
                    state_d = ST_IDLE;          // load done
                    idx_d   = '0;
                end
            end
            ST_IDLE: begin
                if (nv_start) begin
                    state_d = ST_NVWR;          // nv start
                    cnt_d   = CNT_W'(NV_WR_CLKS - 1);
                end
            end
            ST_NVWR: begin
                if (cnt_q == '0) state_d = ST_IDLE;  // nv done
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        load_en  = 1'b0;
        load_idx = idx_q;
        unique case (state_q)
            ST_LOAD: load_en = rst_n;
            ST_IDLE: busy    = 1'b0;
            ST_NVWR: busy    = 1'b1;
            default: busy    = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/nvio_shadow.sv
module nvio_shadow
    import nvio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [2:0]           load_idx,
    input  logic [7:0]           load_data,
    input  logic                 host_we,
    input  logic [2:0]           host_idx,
    input  logic [7:0]           host_data,
    output logic [7:0]           shd_rd [SHADOW_REGS],
    output logic [PIN_COUNT-1:0] pullup_en,
    output logic [PIN_COUNT-1:0] pulldown_en,
    output logic                 see
);

    logic [7:0] regs [SHADOW_REGS];

    for (genvar g = 0; g < SHADOW_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= shadow_factory(3'(g));
            end else if (load_en && load_idx == 3'(g)) begin
                regs[g] <= load_data & shadow_mask(3'(g));
            end else if (host_we && host_idx == 3'(g)) begin
                regs[g] <= host_data & shadow_mask(3'(g));
            end
        end
        assign shd_rd[g] = regs[g];
    end

    assign pullup_en   = {regs[1][0], regs[0]};
    assign pulldown_en = ~{regs[3][0], regs[2]};
    assign see         = regs[4][0];

endmodule

// File: rtl/nvio_regbank.sv
module nvio_regbank
    import nvio_pkg::*;
#(
    parameter int NV_WR_CLKS = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           host_addr,
    input  logic [7:0]           host_wdata,
    input  logic                 host_wr,
    input  logic                 host_rd,
    output logic [7:0]           host_rdata,
    output logic                 host_busy,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pullup_en,
    output logic [PIN_COUNT-1:0] pulldown_en
);

    region_e             region;
    logic [NV_IDX_W-1:0] nv_idx;
    logic [2:0]          sub_idx;
    state_e              state;
    logic                busy;
    logic                load_active;
    logic [2:0]          load_idx;
    logic                see_bit;
    logic [7:0]          nv_rdata;
    logic [7:0]          nv_load_data;
    logic [7:0]          shd_rd [SHADOW_REGS];
    logic [7:0]          sram [SRAM_SIZE];
    logic [PIN_COUNT-1:0] pin_meta, pin_sync;
    logic                wr_go, shd_we, nv_we, sram_we;
    logic [7:0]          nv_wdata;
    logic [7:0]          rd_mux;

    nvio_decode u_dec (
        .addr    (host_addr),
        .region  (region),
        .nv_idx  (nv_idx),
        .sub_idx (sub_idx)
    );

    assign wr_go   = host_wr && (state == ST_IDLE);
    assign shd_we  = wr_go && (region == RG_SHADOW);
    assign sram_we = wr_go && (region == RG_SRAM);
    assign nv_we   = wr_go && ((region == RG_USER_NV) || (region == RG_SHADOW && !see_bit));
    assign nv_wdata = (region == RG_SHADOW) ? (host_wdata & shadow_mask(sub_idx)) : host_wdata;

    nvio_ctrl_fsm #(.NV_WR_CLKS(NV_WR_CLKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_start (nv_we),
        .state    (state),
        .busy     (busy),
        .load_en  (load_active),
        .load_idx (load_idx)
    );

    nvio_nvstore u_nv (
        .clk     (clk),
        .we      (nv_we),
        .widx    (nv_idx),
        .wdata   (nv_wdata),
        .ridx_a  (nv_idx),
        .rdata_a (nv_rdata),
        .ridx_b  (NV_IDX_W'(SHD_NV_BASE) + NV_IDX_W'(load_idx)),
        .rdata_b (nv_load_data)
    );

    nvio_shadow u_shd (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_active),
        .load_idx    (load_idx),
        .load_data   (nv_load_data),
        .host_we     (shd_we),
        .host_idx    (sub_idx),
        .host_data   (host_wdata),
        .shd_rd      (shd_rd),
        .pullup_en   (pullup_en),
        .pulldown_en (pulldown_en),
        .see         (see_bit)
    );

    for (genvar g = 0; g < SRAM_SIZE; g++) begin : g_sram
        always_ff @(posedge clk) begin
            if (!rst_n)                             sram[g] <= '0;
            else if (sram_we && sub_idx == 3'(g))   sram[g] <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_meta <= '0;
            pin_sync <= '0;
        end else begin
            pin_meta <= pin_in;
            pin_sync <= pin_meta;
        end
    end

    always_comb begin
        rd_mux = 8'h00;
        unique case (region)
            RG_USER_NV:  rd_mux = nv_rdata;
            RG_SHADOW:   rd_mux = shd_rd[sub_idx];
            RG_STATUS:   rd_mux = (sub_idx == 3'd0) ? pin_sync[7:0] : {7'b0, pin_sync[8]};
            RG_SRAM:     rd_mux = sram[sub_idx];
            RG_RESERVED: rd_mux = 8'h00;
            default:     rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assign host_busy = busy || !rst_n;

endmodule

// File: rtl/nvio_regbank_chk.sv
module nvio_regbank_chk #(
    parameter int NV_WR_CLKS = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] host_addr,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic       host_busy,
    input logic [8:0] pullup_en,
    input logic [8:0] pulldown_en,
    input logic       loading,
    input logic       see
);

    logic shd_addr, user_addr, rsvd_addr;
    assign shd_addr  = host_addr >= 8'hF0 && host_addr <= 8'hF4;
    assign user_addr = host_addr <= 8'h3F || (host_addr >= 8'hF5 && host_addr <= 8'hF7);
    assign rsvd_addr = host_addr >= 8'h40 && host_addr <= 8'hEF;

    logic [31:0] run;
    always_ff @(posedge clk) begin
        if (!rst_n)                  run <= '0;
        else if (host_busy && !loading) run <= run + 1;
        else                         run <= '0;
    end

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= NV_WR_CLKS);

    p_wt_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy && host_wr && shd_addr && !see |=> host_busy);

    p_fast_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy && host_wr && shd_addr && see |=> !host_busy);

    p_user_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy && host_wr && user_addr |=> host_busy);

    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy && host_wr && rsvd_addr |=> !host_busy && $stable(pullup_en) && $stable(pulldown_en));

    p_drop_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy && !loading && host_wr |=> $stable(pullup_en) && $stable(pulldown_en));

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_addr == 8'hF9 || host_addr == 8'hF4) |=> host_rdata[7:1] == 7'd0);

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd && $past(rst_n) |=> $stable(host_rdata));

endmodule

bind nvio_regbank nvio_regbank_chk #(.NV_WR_CLKS(NV_WR_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .host_busy   (host_busy),
    .pullup_en   (pullup_en),
    .pulldown_en (pulldown_en),
    .loading     (load_active),
    .see         (see_bit)
);

// File: tb/nvio_regbank_test.sv
`timescale 1ns/1ps
module nvio_regbank_test;

    localparam int WRC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_busy;
    logic [8:0] pin_in = '0;
    logic [8:0] pullup_en, pulldown_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nvio_regbank #(.NV_WR_CLKS(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .host_busy(host_busy),
        .pin_in(pin_in), .pullup_en(pullup_en), .pulldown_en(pulldown_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && host_busy; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        for (int i = 0; i < 1000 && host_busy; i++) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 busy in load", host_busy, 1);
        wait_idle();
        chk("R1 pullup default", pullup_en, 9'h000);
        chk("R1 pulldown default", pulldown_en, 9'h000);
        rd(8'hF2, d); chk("R1 F2 factory", d, 8'hFF);
        rd(8'hF3, d); chk("R1 F3 factory", d, 8'h01);
    endtask

    task automatic t_pullup();
        logic [7:0] d;
        int n;
        wr(8'hF0, 8'hA5);
        busy_len(n); chk("R4 busy length", n, WRC);
        wr(8'hF1, 8'hFF); wait_idle();
        chk("R2 pullup map", pullup_en, 9'h1A5);
        rd(8'hF1, d); chk("R11 F1 upper bits", d, 8'h01);
    endtask

    task automatic t_control();
        wr(8'hF2, 8'h3C); wait_idle();
        wr(8'hF3, 8'h00); wait_idle();
        chk("R3 pulldown map", pulldown_en, 9'h1C3);
    endtask

    task automatic t_user();
        logic [7:0] d;
        int n;
        wr(8'h00, 8'h11); busy_len(n); chk("R6 busy length", n, WRC);
        wr(8'h3F, 8'h22); wait_idle();
        wr(8'hF5, 8'h33); wait_idle();
        wr(8'hF7, 8'h44); wait_idle();
        rd(8'h00, d); chk("R6 rd 00", d, 8'h11);
        rd(8'h3F, d); chk("R6 rd 3F", d, 8'h22);
        rd(8'hF5, d); chk("R6 rd F5", d, 8'h33);
        rd(8'hF7, d); chk("R6 rd F7", d, 8'h44);
        host_addr = 8'h00;
        repeat (2) @(negedge clk);
        chk("R12 rdata held", host_rdata, 8'h44);
    endtask

    task automatic t_sram();
        logic [7:0] d;
        wr(8'hFA, 8'h5A);
        chk("R7 no busy", host_busy, 0);
        wr(8'hFF, 8'hA5);
        rd(8'hFA, d); chk("R7 rd FA", d, 8'h5A);
        rd(8'hFF, d); chk("R7 rd FF", d, 8'hA5);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(8'h40, 8'h77);
        chk("R8 no busy", host_busy, 0);
        wr(8'hEF, 8'h88);
        rd(8'h40, d); chk("R8 rd 40", d, 8'h00);
        rd(8'hEF, d); chk("R8 rd EF", d, 8'h00);
        chk("R8 pullup kept", pullup_en, 9'h1A5);
        chk("R8 pulldown kept", pulldown_en, 9'h1C3);
    endtask

    task automatic t_status();
        logic [7:0] d;
        pin_in = 9'h1AB;
        repeat (3) @(negedge clk);
        rd(8'hF8, d); chk("R9 F8", d, 8'hAB);
        rd(8'hF9, d); chk("R9/R11 F9", d, 8'h01);
        wr(8'hF8, 8'h00);
        rd(8'hF8, d); chk("R9 write ignored", d, 8'hAB);
        pin_in = 9'h054;
        repeat (3) @(negedge clk);
        rd(8'hF9, d); chk("R9 F9 low", d, 8'h00);
    endtask

    task automatic t_busy_drop();
        logic [7:0] d;
        wr(8'hF0, 8'h0F);
        wr(8'hF0, 8'hF0);
        wr(8'hFA, 8'h11);
        wait_idle();
        chk("R10 shadow write dropped", pullup_en, 9'h10F);
        rd(8'hFA, d); chk("R10 sram write dropped", d, 8'h5A);
    endtask

    task automatic t_shadow_mode();
        logic [7:0] d;
        wr(8'hF2, 8'h0F); wait_idle();
        wr(8'hF4, 8'h01); wait_idle();
        rd(8'hF4, d); chk("R5 mode set", d, 8'h01);
        wr(8'hF2, 8'hF0);
        chk("R5 no busy", host_busy, 0);
        chk("R5 shadow applied", pulldown_en, 9'h10F);
        wr(8'h01, 8'h99);
        chk("R6 busy with mode set", host_busy, 1);
        wait_idle();
        do_reset(); wait_idle();
        chk("R5 reload nv value", pulldown_en, 9'h1F0);
        chk("R1 reload pullup", pullup_en, 9'h10F);
        rd(8'h01, d); chk("R6 kept over reset", d, 8'h99);
        rd(8'hFF, d); chk("R7 sram cleared", d, 8'h00);
        rd(8'hF4, d); chk("R5 mode reloaded", d, 8'h01);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pullup();
        t_control();
        t_user();
        t_sram();
        t_reserved();
        t_status();
        t_busy_drop();
        t_shadow_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule